// File: doc/BRIEF.md
# Pixel Stream Character Serializer

This block turns a parallel 10-bit pixel interface into a single serial bit stream that runs at one bit per fast clock. Every pixel word leaves as a 12-bit character: a start bit, the ten payload bits with the least significant first, and a stop bit. The frame and line strobes travel inside the stream itself rather than on separate wires.

The pixel side works at the character rate. Once every twelve fast clocks the block raises `pix_load` for one cycle. The rising edge at the end of that cycle samples `pix_data`, `line_vld` and `frame_vld`, and the character chosen from them goes out next. So the source changes its inputs once per character period, and `pix_load` serves as its divided clock enable.

When the frame strobe is seen going high, the block inserts a reserved three-character marker (all ones, all zeros, all ones). During blanking it sends idle characters whose payload is zero. Pixel values are clamped below all ones, so the marker can never appear inside pixel data. A receiver can rebuild both strobes by spotting the marker after a run of idles and counting characters from there.

Top module: `pix_char_ser`

## Requirements
- R1: Each character is 12 fast-clock bits long. Its first bit (start) is 1 and its last bit (stop) is 0.
- R2: The ten payload bits follow the start bit least significant bit first, so payload bit k is sent in bit slot k+1 of the character.
- R3: `pix_load` is high exactly in the stop-bit cycle of every character, and never in two consecutive cycles. The inputs are sampled at the rising edge that ends that cycle, and the selected character starts on the next cycle.
- R4: While `rst_n` is low, `ser_out` is 1 and `pix_load` is 0. The first character after reset is an idle character.
- R5: Until the first frame-strobe rising edge after reset, every character is idle (payload 0x000), whatever `line_vld` and `pix_data` are. A frame strobe that is already high during reset does not count as a rising edge.
- R6: When a load edge sees `frame_vld` high after it was low at the previous load edge, the next three characters carry 0x3FF, 0x000 and 0x3FF. Inputs sampled during the marker have no effect on those characters.
- R7: Once a marker has been sent, a load edge that sees both `frame_vld` and `line_vld` high sends `pix_data` as the payload. The value 0x3FF is replaced by 0x3FE.
- R8: Once a marker has been sent, a load edge that sees `frame_vld` or `line_vld` low sends an idle character.
- R9: The frame strobe is examined only at load edges. A pulse that rises and falls between two load edges causes no marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_data | input | 10 | Pixel word, sampled at load edges |
| line_vld | input | 1 | Line active strobe, sampled at load edges |
| frame_vld | input | 1 | Frame active strobe, sampled at load edges |
| ser_out | output | 1 | Serial character stream |
| pix_load | output | 1 | Character-rate strobe, high in each stop-bit cycle |

## Verification
The block has little state: a bit counter, a payload register, a marker phase and a record of the last frame strobe, so any fault in it appears on `ser_out` within one character. A counter that slips moves `pix_load` and the start and stop bits out of their twelve-cycle grid straight away. A wrong marker phase or edge record shows up as a missing, duplicated or misplaced 0x3FF character in the three characters that follow a frame edge. A wrong payload bit order or a missing clamp shows up in the first pixel character of a line.

// File: rtl/pix_char_ser.sv
module pix_char_ser #(
  parameter int PAY_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAY_W-1:0] pix_data,
  input  logic             line_vld,
  input  logic             frame_vld,
  output logic             ser_out,
  output logic             pix_load
);
  localparam int CHAR_W = PAY_W + 2;
  localparam int CW = $clog2(CHAR_W);
  localparam logic [PAY_W-1:0] MARK  = '1;
  localparam logic [PAY_W-1:0] CLAMP = MARK - PAY_W'(1);
  localparam logic [CW-1:0] LAST = CW'(CHAR_W - 1);

  typedef enum logic [1:0] {MK_NONE, MK_ZERO, MK_TAIL} mk_t;

  logic [CW-1:0]    bit_cnt;
  logic [CW-1:0]    idx;
  logic [PAY_W-1:0] cur, nxt;
  mk_t              mk, mk_nxt;
  logic             prev_fv, armed, rise;

  assign pix_load = (bit_cnt == LAST);
  assign idx      = bit_cnt - CW'(1);
  assign rise     = frame_vld & ~prev_fv;

  always_comb begin
    if (bit_cnt == '0)   ser_out = 1'b1;
    else if (pix_load)   ser_out = 1'b0;
    else                 ser_out = cur[idx];
  end

  always_comb begin
    mk_nxt = MK_NONE;
    nxt    = '0;
    if (mk == MK_ZERO) begin
      mk_nxt = MK_TAIL;
    end else if (mk == MK_TAIL) begin
      nxt = MARK;
    end else if (rise) begin
      nxt    = MARK;
      mk_nxt = MK_ZERO;
    end else if (armed && frame_vld && line_vld) begin
      nxt = (pix_data == MARK) ? CLAMP : pix_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      cur     <= '0;
      mk      <= MK_NONE;
      prev_fv <= 1'b1;
      armed   <= 1'b0;
    end else begin
      bit_cnt <= pix_load ? '0 : bit_cnt + CW'(1);
      if (pix_load) begin
        cur     <= nxt;
        mk      <= mk_nxt;
        prev_fv <= frame_vld;
        if (mk == MK_NONE && rise) armed <= 1'b1;
      end
    end
  end

  // R1
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_load |=> ser_out);

  // R3
  load_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_load |=> !pix_load);

  // R5
  idle_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (cur == '0));

  // R6
  marker_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_load && mk == MK_ZERO) |=> (cur == '0 && mk == MK_TAIL));

  // R6
  marker_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_load && mk == MK_TAIL) |=> (cur == MARK && mk == MK_NONE));

  // R7
  no_mark_in_pixels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_load && mk == MK_NONE && !rise) |=> (cur != MARK));
endmodule

// File: tb/sim_pix_char_ser.sv
`timescale 1ns/1ps
module sim_pix_char_ser;
  localparam int NCH = 92;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] pix_data = '0;
  logic line_vld = 1'b0, frame_vld = 1'b0;
  logic ser_out, pix_load;
  int checks = 0, fails = 0, cyc = 0;
  bit qb[$];
  string qt[$];
  int m_mk = 0;
  bit m_prev = 1'b1, m_armed = 1'b0, glitch = 1'b0;

  always #4 clk = ~clk;

  pix_char_ser u0 (.clk(clk), .rst_n(rst_n), .pix_data(pix_data), .line_vld(line_vld),
                   .frame_vld(frame_vld), .ser_out(ser_out), .pix_load(pix_load));

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic push_char(input logic [9:0] p, input string tag);
    qb.push_back(1'b1); qt.push_back("R1 start");
    for (int j = 0; j < 10; j++) begin
      qb.push_back(p[j]); qt.push_back({"R2/", tag});
    end
    qb.push_back(1'b0); qt.push_back("R1 stop");
  endtask

  task automatic load_model();
    logic [9:0] p;
    string t;
    p = '0;
    t = glitch ? "R9" : (m_armed ? "R8" : "R5");
    if (m_mk == 1) begin m_mk = 2; t = "R6"; end
    else if (m_mk == 2) begin m_mk = 0; p = 10'h3FF; t = "R6"; end
    else if (frame_vld && !m_prev) begin
      m_mk = 1; m_armed = 1'b1; p = 10'h3FF; t = "R6";
    end else if (m_armed && frame_vld && line_vld) begin
      p = (pix_data == 10'h3FF) ? 10'h3FE : pix_data; t = "R7";
    end
    m_prev = frame_vld;
    push_char(p, t);
  endtask

  task automatic stim(input int c);
    glitch = 1'b0;
    line_vld = 1'b1;
    pix_data = 10'((c * 37 + 5) & 10'h3FF);
    if (c < 4) begin frame_vld = 1'b1; pix_data = 10'h2AA; end
    else if (c < 7) frame_vld = 1'b0;
    else if (c == 7) begin frame_vld = 1'b0; glitch = 1'b1; end
    else if (c < 11) begin frame_vld = 1'b1; pix_data = 10'h3FF; end
    else if (c < 41) begin
      frame_vld = 1'b1;
      line_vld = ((c - 11) % 10) < 6;
      case (c)
        12: pix_data = 10'h3FF;
        13: pix_data = 10'h000;
        14: pix_data = 10'h3FE;
        15: pix_data = 10'h001;
        16: pix_data = 10'h200;
        default: ;
      endcase
    end
    else if (c < 51) frame_vld = 1'b0;
    else if (c == 51) begin frame_vld = 1'b0; glitch = 1'b1; end
    else if (c < 54) frame_vld = 1'b0;
    else if (c < 71) frame_vld = 1'b1;
    else if (c == 71) frame_vld = 1'b0;
    else if (c < 81) begin frame_vld = 1'b1; if (c == 75) pix_data = 10'h3FF; end
    else frame_vld = 1'b0;
  endtask

  initial begin
    stim(0);
    push_char(10'h000, "R4");
    repeat (3) @(negedge clk);
    chk(ser_out, 1'b1, "R4 reset ser_out");
    chk(pix_load, 1'b0, "R4 reset pix_load");
    rst_n = 1'b1;
    for (int k = 0; k < NCH * 12; k++) begin
      if (k > 0) @(negedge clk);
      cyc = k;
      chk(ser_out, qb.pop_front(), qt.pop_front());
      chk(pix_load, (k % 12) == 11, "R3");
      if ((k % 12) == 5 && glitch) frame_vld = 1'b1;
      if ((k % 12) == 7 && glitch) frame_vld = 1'b0;
      if ((k % 12) == 11) load_model();
      if ((k % 12) == 0 && k > 0) stim(k / 12);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule